// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a host request port and an asynchronous extended-data-out DRAM with a narrow data path. It takes one read or write per valid/ready handshake and splits the linear address: the upper bits select a row and the lower bits select a column. Both halves go out on one shared address bus. The block then drives the row strobe, column strobe, write enable and output enable. Every minimum pulse, delay and precharge is given as a nanosecond parameter and rounded up to whole clock cycles.

A row stays open after each column access for as long as the next request targets the same row and the row-low time budget allows another page cycle. The sequencer then runs an EDO page cycle: it raises only the column strobe, presents the new column and lowers the strobe again. When the next request targets another row, or the budget is spent, the row is closed and a full row precharge follows. Writes are early writes: write enable goes low before the column strobe falls, so the DRAM never drives its data pins. Read data is captured in the last cycle before the column strobe rises and is returned with a one-cycle `rd_valid` pulse.

Top module: `edo_seq`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n`, `we_n` and `oe_n` are high, and `dq_oe` and `rd_valid` are low.
- R2: The row is `req_addr[23:11]` and the column is `req_addr[10:0]`, zero-extended on `dram_addr`. The row is stable for at least one cycle before `ras_n` falls and for ceil(10 ns / clock) cycles after it falls. The column is stable for at least one cycle before each fall of `cas_n`.
- R3: `ras_n` stays low for at least max(ceil(60 ns), ceil(104 ns) - ceil(40 ns)) cycles. Between two row openings it stays high for at least ceil(40 ns) cycles.
- R4: On a row opening, `cas_n` first falls exactly max(ceil(15 ns), ceil(10 ns) + 1) cycles after `ras_n` falls.
- R5: `cas_n` stays low for at least ceil(10 ns) cycles on a write and at least max(ceil(15 ns), ceil(30 ns), ceil(35 ns) - ceil(10 ns)) cycles on a read. Between page cycles it stays high for at least ceil(10 ns) cycles.
- R6: A write lowers `we_n` at least one cycle before `cas_n` falls and holds it low while `cas_n` is low. `oe_n` stays high and `dq_oe` is high when `cas_n` falls, with the write data on `dq_out`.
- R7: Each read returns, with a one-cycle `rd_valid` pulse just after `cas_n` rises, the `dq_in` value present in the last `cas_n`-low cycle. Reads return their data in request order.
- R8: A request to the row that is already open is served by a page cycle, without `ras_n` rising.
- R9: A request to a different row closes the open row, which then precharges before the new row opens.
- R10: `ras_n` never stays low for ceil(T_RASP) cycles or more. A same-row burst that would pass that limit is split by a close and a reopen.
- R11: `dq_oe` and a low `oe_n` never coincide. After a read, `oe_n` stays low until `ras_n` rises, and `oe_n` only rises together with `ras_n` or for a write.
- R12: `req_ready` is high in idle once precharge is done, and in the last `cas_n`-low cycle when the presented address hits the open row within the budget. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Linear address {row, column} |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 4 | Read data |
| dram_addr | output | 13 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| dq_out | output | 4 | Data driven to the DRAM |
| dq_oe | output | 1 | Controller drives the data pins |
| dq_in | input | 4 | Data from the DRAM |

## Verification
The assertions assume the host changes `req_addr`, `req_write` and `req_wdata` only between handshakes. They also assume the row-low budget is much longer than one row cycle, so the minimum row-low time can always be met before the limit. The bench drives inputs only after an accepted handshake, holds each request stable until `req_ready` is seen, and runs with a shortened row-low budget so that the split of R10 occurs in a burst of a few dozen accesses. The DRAM responder gives wrong data in the first column-low cycle of a read, so an early data capture is visible.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_CAS,
    ST_CP,
    ST_CLOSE
  } seq_state_t;

  // Round a nanosecond minimum up to whole clock cycles.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int ROW_W = 13,
  parameter int COL_W = 11,
  localparam int AW = ROW_W + COL_W
) (
  input  logic [AW-1:0]    lin_addr,
  input  logic [ROW_W-1:0] open_row,
  output logic [ROW_W-1:0] row,
  output logic [ROW_W-1:0] col_bus,
  output logic             same_row
);
  // Upper bits pick the row, lower bits the column; column zero-extended onto the bus.
  assign row      = lin_addr[AW-1 -: ROW_W];
  assign col_bus  = ROW_W'(lin_addr[COL_W-1:0]);
  assign same_row = (row == open_row);
endmodule

// File: rtl/edo_ras_timer.sv
module edo_ras_timer #(
  parameter int RASP_C    = 10000,
  parameter int RAS_MIN_C = 6,
  parameter int PAGE_COST = 8,
  localparam int CW = $clog2(RASP_C + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic min_met,
  output logic page_ok
);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       low_cnt <= '0;
    else if (!ras_low)                low_cnt <= '0;
    else if (int'(low_cnt) != RASP_C) low_cnt <= low_cnt + 1'b1;
  end

  // low_cnt = earlier row-low cycles; the current cycle makes one more.
  assign min_met = int'(low_cnt) >= RAS_MIN_C - 1;
  assign page_ok = int'(low_cnt) + PAGE_COST < RASP_C;
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_seq_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 11,
  parameter int DQ_W      = 4,
  parameter int T_RC_NS   = 104,
  parameter int T_RP_NS   = 40,
  parameter int T_RAS_NS  = 60,
  parameter int T_RASP_NS = 100000,
  parameter int T_RCD_NS  = 15,
  parameter int T_RAH_NS  = 10,
  parameter int T_CAS_NS  = 10,
  parameter int T_CP_NS   = 10,
  parameter int T_CAC_NS  = 15,
  parameter int T_AA_NS   = 30,
  parameter int T_CPA_NS  = 35
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [DQ_W-1:0]        dq_out,
  output logic                   dq_oe,
  input  logic [DQ_W-1:0]        dq_in
);
  localparam int RP_C      = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int RAS_MIN_C = imax(ns_to_cyc(T_RAS_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS) - RP_C);
  localparam int RAH_C     = ns_to_cyc(T_RAH_NS, CLK_NS);
  localparam int RCD_C     = imax(ns_to_cyc(T_RCD_NS, CLK_NS), RAH_C + 1);
  localparam int WR_CAS_C  = ns_to_cyc(T_CAS_NS, CLK_NS);
  localparam int CP_C      = ns_to_cyc(T_CP_NS, CLK_NS);
  localparam int RD_CAS_C  = imax(imax(ns_to_cyc(T_CAC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                  imax(ns_to_cyc(T_CPA_NS, CLK_NS) - CP_C, WR_CAS_C));
  localparam int RASP_C    = ns_to_cyc(T_RASP_NS, CLK_NS);
  localparam int PAGE_COST = CP_C + imax(RD_CAS_C, WR_CAS_C) + 2;
  localparam int SC_W      = $clog2(imax(imax(RCD_C, RD_CAS_C), imax(CP_C, RP_C)) + 1) + 1;

  seq_state_t        state;
  logic [SC_W-1:0]   sc;
  logic [SC_W-1:0]   pre_cnt;
  logic [ROW_W-1:0]  open_row;
  logic [ROW_W-1:0]  cur_col;
  logic              cur_wr;

  logic [ROW_W-1:0]  row;
  logic [ROW_W-1:0]  col_bus;
  logic              same_row;
  logic              min_met;
  logic              page_ok;

  // Named internal events, also used by the bound checker.
  logic idle_ready, cas_last, page_ready, page_accept, idle_accept, row_close;

  edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .lin_addr (req_addr),
    .open_row (open_row),
    .row      (row),
    .col_bus  (col_bus),
    .same_row (same_row)
  );

  edo_ras_timer #(.RASP_C(RASP_C), .RAS_MIN_C(RAS_MIN_C), .PAGE_COST(PAGE_COST)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_low (!ras_n),
    .min_met (min_met),
    .page_ok (page_ok)
  );

  assign idle_ready  = (state == ST_IDLE) && (pre_cnt == '0);
  assign cas_last    = (state == ST_CAS) &&
                       (int'(sc) == (cur_wr ? WR_CAS_C - 1 : RD_CAS_C - 1));
  assign page_ready  = cas_last && same_row && page_ok;
  assign req_ready   = idle_ready || page_ready;
  assign idle_accept = idle_ready && req_valid;
  assign page_accept = page_ready && req_valid;
  assign row_close   = (state == ST_CLOSE) && min_met;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sc        <= '0;
      pre_cnt   <= '0;
      open_row  <= '0;
      cur_col   <= '0;
      cur_wr    <= 1'b0;
      dram_addr <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pre_cnt != '0) pre_cnt <= pre_cnt - 1'b1;
          if (idle_accept) begin
            open_row  <= row;
            cur_col   <= col_bus;
            cur_wr    <= req_write;
            dq_out    <= req_wdata;
            dram_addr <= row;
            state     <= ST_ROW;
          end
        end
        ST_ROW: begin
          ras_n <= 1'b0;
          sc    <= '0;
          state <= ST_RCD;
        end
        ST_RCD: begin
          sc <= sc + 1'b1;
          if (int'(sc) == RAH_C - 1) begin
            dram_addr <= cur_col;
            we_n      <= !cur_wr;
            dq_oe     <= cur_wr;
          end
          if (int'(sc) == RCD_C - 1) begin
            cas_n <= 1'b0;
            oe_n  <= cur_wr;
            sc    <= '0;
            state <= ST_CAS;
          end
        end
        ST_CAS: begin
          sc <= sc + 1'b1;
          if (cas_last) begin
            cas_n <= 1'b1;
            dq_oe <= 1'b0;
            sc    <= '0;
            if (!cur_wr) begin
              rd_data  <= dq_in;
              rd_valid <= 1'b1;
            end
            if (page_accept) begin
              cur_col   <= col_bus;
              dram_addr <= col_bus;
              cur_wr    <= req_write;
              dq_out    <= req_wdata;
              we_n      <= !req_write;
              dq_oe     <= req_write;
              if (req_write) oe_n <= 1'b1;
              state     <= ST_CP;
            end else begin
              state <= ST_CLOSE;
            end
          end
        end
        ST_CP: begin
          sc <= sc + 1'b1;
          if (int'(sc) == CP_C - 1) begin
            cas_n <= 1'b0;
            oe_n  <= cur_wr;
            sc    <= '0;
            state <= ST_CAS;
          end
        end
        ST_CLOSE: begin
          if (row_close) begin
            ras_n   <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            pre_cnt <= SC_W'(RP_C - 1);
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk #(
  parameter int RAS_MIN_C = 6,
  parameter int RP_C      = 4,
  parameter int RAH_C     = 1,
  parameter int RCD_C     = 2,
  parameter int WR_CAS_C  = 1,
  parameter int RD_CAS_C  = 3,
  parameter int CP_C      = 1,
  parameter int RASP_C    = 10000,
  parameter int ABUS_W    = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic [ABUS_W-1:0] dram_addr,
  input logic              page_accept
);
  localparam int CAS_MIN_C = (WR_CAS_C < RD_CAS_C) ? WR_CAS_C : RD_CAS_C;
  localparam int SAT       = 1000000;

  int lo_run, hi_run, clo_run, chi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run  <= 0;
      hi_run  <= RP_C;
      clo_run <= 0;
      chi_run <= CP_C;
    end else begin
      lo_run  <= ras_n ? 0 : lo_run + 1;
      hi_run  <= !ras_n ? 0 : ((hi_run < SAT) ? hi_run + 1 : hi_run);
      clo_run <= cas_n ? 0 : clo_run + 1;
      chi_run <= !cas_n ? 0 : ((chi_run < SAT) ? chi_run + 1 : chi_run);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> ras_n && cas_n && we_n && !dq_oe);
  assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(dram_addr));
  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && lo_run >= 1 && lo_run < RAH_C) |-> $stable(dram_addr));
  assert_col_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(dram_addr));
  assert_ras_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_run >= RAS_MIN_C);
  assert_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_run >= RP_C);
  assert_rcd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !ras_n && lo_run >= RCD_C);
  assert_cas_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> clo_run >= CAS_MIN_C);
  assert_cas_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> chi_run >= CP_C);
  assert_early_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> $past(!we_n) && oe_n && dq_oe);
  assert_we_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !$fell(cas_n) && $past(!we_n)) |-> !we_n);
  assert_read_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> cas_n && $past(!cas_n) && $past(we_n) && $past(clo_run) >= RD_CAS_C - 1);
  assert_page_keeps_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_accept |=> !ras_n && cas_n);
  assert_ras_budget_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> lo_run < RASP_C);
  assert_bus_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));
  assert_oe_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> ras_n || dq_oe);
endmodule

bind edo_seq edo_seq_chk #(
  .RAS_MIN_C (RAS_MIN_C),
  .RP_C      (RP_C),
  .RAH_C     (RAH_C),
  .RCD_C     (RCD_C),
  .WR_CAS_C  (WR_CAS_C),
  .RD_CAS_C  (RD_CAS_C),
  .CP_C      (CP_C),
  .RASP_C    (RASP_C),
  .ABUS_W    (ROW_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .oe_n        (oe_n),
  .dq_oe       (dq_oe),
  .rd_valid    (rd_valid),
  .dram_addr   (dram_addr),
  .page_accept (page_accept)
);

// File: tb/tb_edo_seq.sv
module tb_edo_seq;
  // Bench restates the cycle counts at an 8 ns clock, independently of the RTL.
  localparam int CK     = 8;
  localparam int E_RP   = (40 + CK - 1) / CK;
  localparam int E_RAS  = ((60 + CK - 1) / CK > (104 + CK - 1) / CK - E_RP) ?
                          (60 + CK - 1) / CK : (104 + CK - 1) / CK - E_RP;
  localparam int E_RCD  = 3;   // max(ceil(15/8)=2, ceil(10/8)+1=3)
  localparam int E_WCAS = 2;   // ceil(10/8)
  localparam int E_RCAS = 4;   // max(2, ceil(30/8)=4, ceil(35/8)-2=3)
  localparam int E_CP   = 2;
  localparam int E_RASP = (600 + CK - 1) / CK;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic [3:0]  dq_in = '0;
  logic        req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0]  rd_data, dq_out;
  logic [12:0] dram_addr;

  always #4 clk = ~clk;

  edo_seq #(.CLK_NS(CK), .T_RASP_NS(600)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {wr, same_row_page, 2'b0, data[3:0], addr[23:0]}
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b0, 4'hA, 13'h0005, 11'h00A},
    {1'b1, 1'b1, 2'b0, 4'h3, 13'h0005, 11'h00B},
    {1'b0, 1'b1, 2'b0, 4'h0, 13'h0005, 11'h00A},
    {1'b0, 1'b1, 2'b0, 4'h0, 13'h0005, 11'h00B},
    {1'b1, 1'b0, 2'b0, 4'hF, 13'h1FFF, 11'h7FF},
    {1'b0, 1'b1, 2'b0, 4'h0, 13'h1FFF, 11'h7FF},
    {1'b1, 1'b0, 2'b0, 4'h6, 13'h0000, 11'h000},
    {1'b0, 1'b0, 2'b0, 4'h0, 13'h0005, 11'h00A},
    {1'b1, 1'b1, 2'b0, 4'h9, 13'h0005, 11'h00A},
    {1'b0, 1'b1, 2'b0, 4'h0, 13'h0005, 11'h00A},
    {1'b0, 1'b0, 2'b0, 4'h0, 13'h0000, 11'h000}
  };

  logic [3:0] model [logic [23:0]];
  logic [3:0] dmem  [logic [23:0]];
  logic [3:0] expq  [$];

  function automatic logic [3:0] mrd(input logic [23:0] a);
    return model.exists(a) ? model[a] : 4'h0;
  endfunction

  // ---- DRAM responder and monitors, all at the falling clock edge ----
  bit p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1;
  int lo_r = 0, hi_r = 100, cas_lo = 0, cas_hi = 100;
  int min_lo = 1000, max_lo = 0, min_hi = 1000, min_rcd = 1000, max_rcd = 0;
  int min_wcas = 1000, min_rcas = 1000, min_cp = 1000;
  int n_open = 0, wr_err = 0, ovl_err = 0, hold_ok = 0, hold_bad = 0;
  bit first_cas = 0, cas_wr = 0, last_read = 0, got_first = 0;
  logic [12:0] cur_row = '0, first_row = '0;
  logic [10:0] cur_col = '0, first_col = '0;
  logic [3:0]  rv;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n) begin
        if (p_ras) begin
          if (hi_r < min_hi) min_hi = hi_r;
          n_open++; lo_r = 1; first_cas = 1; cur_row = dram_addr;
        end else lo_r++;
        if (lo_r > max_lo) max_lo = lo_r;
      end else begin
        if (!p_ras) begin
          if (lo_r < min_lo) min_lo = lo_r;
          if (last_read) begin if (!p_oe) hold_ok++; else hold_bad++; end
          hi_r = 1;
        end else hi_r++;
      end
      if (!cas_n) begin
        if (p_cas) begin
          cas_lo = 1; cur_col = dram_addr[10:0];
          if (!got_first) begin got_first = 1; first_row = cur_row; first_col = cur_col; end
          if (first_cas) begin
            if (lo_r - 1 < min_rcd) min_rcd = lo_r - 1;
            if (lo_r - 1 > max_rcd) max_rcd = lo_r - 1;
            first_cas = 0;
          end else if (cas_hi < min_cp) min_cp = cas_hi;
          cas_wr = !we_n; last_read = we_n;
          if (!we_n) begin
            if (p_we || !dq_oe || !oe_n) wr_err++;
            dmem[{cur_row, cur_col}] = dq_out;
          end
        end else begin
          cas_lo++;
          if (cas_wr && we_n) wr_err++;
        end
        if (!cas_wr) begin
          rv = dmem.exists({cur_row, cur_col}) ? dmem[{cur_row, cur_col}] : 4'h0;
          dq_in = (cas_lo >= 2) ? rv : ~rv;   // invalid in the first low cycle
        end
      end else begin
        if (!p_cas) begin
          if (cas_wr) begin if (cas_lo < min_wcas) min_wcas = cas_lo; end
          else if (cas_lo < min_rcas) min_rcas = cas_lo;
          cas_hi = 1;
        end else cas_hi++;
      end
      if (dq_oe && !oe_n) ovl_err++;
      if (rd_valid) begin
        if (expq.size() == 0) chk(1'b0, "R7 unexpected rd_valid", 1, 0);
        else begin
          rv = expq.pop_front();
          chk(rd_data == rv, "R7 read data", int'(rd_data), int'(rv));
        end
      end
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n;
    end
  end

  task automatic issue(input bit wr, input logic [23:0] a, input logic [3:0] d);
    if (wr) model[a] = d; else expq.push_back(mrd(a));
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    int k = 0;
    while (expq.size() != 0 && k < 2000) begin @(negedge clk); k++; end
    repeat (30) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R12 handshake actual=hung expected=complete");
      finish_run();
    end
  end

  int exp_opens = 0;
  int opens0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid, "R1 reset outputs",
        int'({ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid}), 6'b111100);
    rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready, "R12 ready in idle", int'(req_ready), 1);

    // Vector walk: pages, row misses, boundary row/column.
    for (int i = 0; i < NV; i++) begin
      if (!VEC[i][30]) exp_opens++;
      issue(VEC[i][31], VEC[i][23:0], VEC[i][27:24]);
    end
    drain();
    chk(n_open == exp_opens, "R8/R9 row openings", n_open, exp_opens);
    chk(first_row == 13'h0005, "R2 row on bus at RAS fall", int'(first_row), 5);
    chk(first_col == 11'h00A, "R2 column on bus at CAS fall", int'(first_col), 10);
    chk(min_lo >= E_RAS, "R3 RAS low width", min_lo, E_RAS);
    chk(min_hi >= E_RP, "R3 RAS precharge", min_hi, E_RP);
    chk(min_rcd == E_RCD && max_rcd == E_RCD, "R4 RAS to CAS delay", min_rcd, E_RCD);
    chk(min_wcas >= E_WCAS, "R5 write CAS width", min_wcas, E_WCAS);
    chk(min_rcas >= E_RCAS, "R5 read CAS width", min_rcas, E_RCAS);
    chk(min_cp >= E_CP, "R5 CAS precharge", min_cp, E_CP);
    chk(wr_err == 0, "R6 early write WE/OE/data", wr_err, 0);

    // R12: busy after an accept, even with a request pending.
    issue(1'b1, {13'h0042, 11'h001}, 4'h7);
    req_valid = 1; req_write = 1'b0; req_addr = {13'h0043, 11'h002};
    #1;
    chk(!req_ready, "R12 not ready while busy", int'(req_ready), 0);
    req_valid = 0;
    issue(1'b0, {13'h0043, 11'h002}, 4'h0);
    issue(1'b0, {13'h0042, 11'h001}, 4'h0);
    drain();

    // R10: long same-row bursts must be split before the budget runs out.
    opens0 = n_open; max_lo = 0;
    for (int i = 0; i < 30; i++) issue(1'b1, {13'h0007, 11'(i)}, 4'(i * 5 + 1));
    for (int i = 0; i < 30; i++) issue(1'b0, {13'h0007, 11'(i)}, 4'h0);
    drain();
    chk(n_open - opens0 >= 3, "R10 burst split by reopen", n_open - opens0, 3);
    chk(max_lo < E_RASP, "R10 RAS low budget", max_lo, E_RASP);
    chk(ovl_err == 0, "R11 no bus contention", ovl_err, 0);
    chk(hold_ok > 0 && hold_bad == 0, "R11 OE held to RAS rise", hold_bad, 0);
    chk(expq.size() == 0, "R7 all reads returned", expq.size(), 0);
    finish_run();
  end
endmodule